// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block compares two double-precision floating-point operands, or one operand against zero, and records the outcome as a four-bit flag word of the form {N, Z, C, V}. There are four outcomes: equal, less than, greater than, and unordered. The unordered outcome is produced when a NaN takes part. The flag word is written into a floating-point status flag register. It never goes straight to the integer side.

A separate transfer strobe copies the stored status flags into an integer flag register, which later condition checks read. A compare returns its result one clock after its start strobe. The block raises a one-cycle done pulse in that cycle, and the status flags change at the same clock edge.

Operands are always signed, and there is no unsigned mode. When the compare-with-zero select is high, positive zero takes the place of the second operand.

Top module: `fp_cmp_flags`

## Requirements
- R1: After reset, done_o is 0, fpsr_flags_o is 4'b0000 and int_flags_o is 4'b0000.
- R2: Operands that are numerically equal give the flags {N,Z,C,V} = 4'b0110. Positive zero and negative zero compare equal.
- R3: When operand A is below operand B as a signed value, the flags are 4'b1000. Every negative value lies below every positive value, and of two negative values the one with the larger magnitude is lower.
- R4: When operand A is above operand B, the flags are 4'b0010.
- R5: If either operand is a NaN, the result is unordered and the flags are 4'b0011. A NaN has all exponent bits (62:52) set and a nonzero fraction (51:0).
- R6: While zero_sel_i is 1, operand B is replaced by +0.0. The value on op_b_i then has no effect on the result, even when it is a NaN.
- R7: done_o is 1 in exactly the cycle after a cycle with start_i high. fpsr_flags_o updates at that same edge and otherwise holds its value.
- R8: int_flags_o changes only at an edge where xfer_i is high. At that edge it takes the value fpsr_flags_o had in the xfer_i cycle. A compare never writes int_flags_o.
- R9: A transfer in the same cycle as a start copies the old status flags. A transfer one cycle later copies the new flags.
- R10: Infinities (all exponent bits set, zero fraction) compare by sign like ordinary values. +inf is above every finite value, -inf is below every finite value, and +inf equals +inf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Compare start strobe |
| op_a_i | input | 64 | First operand |
| op_b_i | input | 64 | Second operand, ignored while zero_sel_i is high |
| zero_sel_i | input | 1 | Compare operand A against +0.0 |
| xfer_i | input | 1 | Copy status flags into the integer flag register |
| done_o | output | 1 | One-cycle pulse as the compare result lands |
| fpsr_flags_o | output | 4 | Status register flags {N,Z,C,V} |
| int_flags_o | output | 4 | Integer-side flags {N,Z,C,V} |

## Verification
The bench uses the default parameters: an 11-bit exponent and a 52-bit fraction, which gives the full double-precision layout. With these values it can reach the exponent-all-ones boundary that separates infinities from quiet and signalling NaNs. It can also reach the smallest subnormal against signed zero. The bench also tests the sign-reversed magnitude ordering of two negative numbers. Because the layout is full width, the 64-bit constants in the vector table are real IEEE encodings.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_LT = 2'd1,
    CMP_GT = 2'd2,
    CMP_UN = 2'd3
  } cmp_res_e;

  localparam int FLAG_W = 4;

  // flag word layout {N, Z, C, V}
  function automatic logic [FLAG_W-1:0] flags_of(input cmp_res_e r);
    case (r)
      CMP_EQ:  flags_of = 4'b0110;
      CMP_LT:  flags_of = 4'b1000;
      CMP_GT:  flags_of = 4'b0010;
      default: flags_of = 4'b0011;
    endcase
  endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0]           val_i,
  output logic                   sign_o,
  output logic                   nan_o,
  output logic                   zero_o,
  output logic [EXP_W+MAN_W-1:0] mag_o
);
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] frac;

  assign expo   = val_i[W-2 -: EXP_W];
  assign frac   = val_i[MAN_W-1:0];
  assign sign_o = val_i[W-1];
  assign mag_o  = val_i[W-2:0];
  assign nan_o  = (&expo) && (|frac);
  assign zero_o = ~|val_i[W-2:0];
endmodule

// File: rtl/fcmp_decide.sv
module fcmp_decide #(
  parameter int MAG_W = 63
) (
  input  logic             sa_i,
  input  logic             sb_i,
  input  logic             nan_a_i,
  input  logic             nan_b_i,
  input  logic             zero_a_i,
  input  logic             zero_b_i,
  input  logic [MAG_W-1:0] mag_a_i,
  input  logic [MAG_W-1:0] mag_b_i,
  output fcmp_pkg::cmp_res_e res_o
);
  import fcmp_pkg::*;

  function automatic cmp_res_e decide(
    input logic sa, input logic sb, input logic na, input logic nb,
    input logic za, input logic zb,
    input logic [MAG_W-1:0] ma, input logic [MAG_W-1:0] mb);
    if (na || nb)               decide = CMP_UN;
    else if (za && zb)          decide = CMP_EQ;
    else if (sa != sb)          decide = sa ? CMP_LT : CMP_GT;
    else if (ma == mb)          decide = CMP_EQ;
    else if ((ma < mb) ^ sa)    decide = CMP_LT;
    else                        decide = CMP_GT;
  endfunction

  assign res_o = decide(sa_i, sb_i, nan_a_i, nan_b_i, zero_a_i, zero_b_i,
                        mag_a_i, mag_b_i);
endmodule

// File: rtl/fcmp_flag_regs.sv
module fcmp_flag_regs #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_fire_i,
  input  logic          xfer_fire_i,
  input  logic [FW-1:0] new_flags_i,
  output logic          done_o,
  output logic [FW-1:0] fpsr_o,
  output logic [FW-1:0] intf_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      fpsr_o <= '0;
      intf_o <= '0;
    end else begin
      done_o <= cmp_fire_i;
      if (cmp_fire_i)  fpsr_o <= new_flags_i;
      if (xfer_fire_i) intf_o <= fpsr_o;
    end
  end
endmodule

// File: rtl/fp_cmp_flags.sv
module fp_cmp_flags #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  localparam int W = 1 + EXP_W + MAN_W,
  localparam int MAG_W = EXP_W + MAN_W,
  localparam int FW = fcmp_pkg::FLAG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [W-1:0]  op_a_i,
  input  logic [W-1:0]  op_b_i,
  input  logic          zero_sel_i,
  input  logic          xfer_i,
  output logic          done_o,
  output logic [FW-1:0] fpsr_flags_o,
  output logic [FW-1:0] int_flags_o
);
  import fcmp_pkg::*;

  logic [W-1:0]     opnd   [2];
  logic             sgn    [2];
  logic             is_nan [2];
  logic             is_zero[2];
  logic [MAG_W-1:0] mag    [2];

  // named events for the checker
  logic      cmp_fire;
  logic      xfer_fire;
  cmp_res_e  cmp_res;
  logic [FW-1:0] cmp_flags;

  assign opnd[0]   = op_a_i;
  assign opnd[1]   = zero_sel_i ? '0 : op_b_i;
  assign cmp_fire  = start_i;
  assign xfer_fire = xfer_i;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .val_i  (opnd[i]),
      .sign_o (sgn[i]),
      .nan_o  (is_nan[i]),
      .zero_o (is_zero[i]),
      .mag_o  (mag[i])
    );
  end

  fcmp_decide #(.MAG_W(MAG_W)) u_dec (
    .sa_i     (sgn[0]),
    .sb_i     (sgn[1]),
    .nan_a_i  (is_nan[0]),
    .nan_b_i  (is_nan[1]),
    .zero_a_i (is_zero[0]),
    .zero_b_i (is_zero[1]),
    .mag_a_i  (mag[0]),
    .mag_b_i  (mag[1]),
    .res_o    (cmp_res)
  );

  assign cmp_flags = flags_of(cmp_res);

  fcmp_flag_regs #(.FW(FW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_fire_i  (cmp_fire),
    .xfer_fire_i (xfer_fire),
    .new_flags_i (cmp_flags),
    .done_o      (done_o),
    .fpsr_o      (fpsr_flags_o),
    .intf_o      (int_flags_o)
  );
endmodule

// File: rtl/fcmp_chk.sv
module fcmp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmp_fire,
  input logic       xfer_fire,
  input logic [3:0] cmp_flags,
  input logic       done_o,
  input logic [3:0] fpsr_flags_o,
  input logic [3:0] int_flags_o
);
  // R7
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> done_o);
  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_fire |=> !done_o);
  // R7
  fpsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_fire |=> $stable(fpsr_flags_o));
  // R7
  fpsr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> fpsr_flags_o == $past(cmp_flags));
  // R8
  int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_fire |=> $stable(int_flags_o));
  // R9
  int_copy_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_fire |=> int_flags_o == $past(fpsr_flags_o));
  // R5
  unord_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && fpsr_flags_o[0] |-> fpsr_flags_o == 4'b0011);
  // R2
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (fpsr_flags_o == 4'b0110 || fpsr_flags_o == 4'b1000 ||
                fpsr_flags_o == 4'b0010 || fpsr_flags_o == 4'b0011));
endmodule

bind fp_cmp_flags fcmp_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmp_fire     (cmp_fire),
  .xfer_fire    (xfer_fire),
  .cmp_flags    (cmp_flags),
  .done_o       (done_o),
  .fpsr_flags_o (fpsr_flags_o),
  .int_flags_o  (int_flags_o)
);

// File: tb/tb_fp_cmp_flags.sv
module tb_fp_cmp_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] op_a_i = '0;
  logic [63:0] op_b_i = '0;
  logic        zero_sel_i = 1'b0;
  logic        xfer_i = 1'b0;
  logic        done_o;
  logic [3:0]  fpsr_flags_o;
  logic [3:0]  int_flags_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  fp_cmp_flags dut (.*);

  localparam logic [63:0] P1 = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] P2 = 64'h4000_0000_0000_0000;
  localparam logic [63:0] M1 = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] M2 = 64'hC000_0000_0000_0000;
  localparam logic [63:0] PZ = 64'h0;
  localparam logic [63:0] MZ = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PI = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] MI = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] SB = 64'h0000_0000_0000_0001;

  localparam logic [3:0] F_EQ = 4'b0110;
  localparam logic [3:0] F_LT = 4'b1000;
  localparam logic [3:0] F_GT = 4'b0010;
  localparam logic [3:0] F_UN = 4'b0011;

  localparam int NV = 16;
  // {a, b, zero_sel, expected flags}
  localparam logic [132:0] VEC [NV] = '{
    {P1, P1, 1'b0, F_EQ},  // R2
    {PZ, MZ, 1'b0, F_EQ},  // R2 signed zeros
    {P1, P2, 1'b0, F_LT},  // R3
    {M2, M1, 1'b0, F_LT},  // R3 two negatives
    {M1, P1, 1'b0, F_LT},  // R3 sign differs
    {P2, P1, 1'b0, F_GT},  // R4
    {M1, M2, 1'b0, F_GT},  // R4
    {QN, P1, 1'b0, F_UN},  // R5
    {P1, SN, 1'b0, F_UN},  // R5 signalling NaN
    {PI, P2, 1'b0, F_GT},  // R10
    {MI, M2, 1'b0, F_LT},  // R10
    {PI, PI, 1'b0, F_EQ},  // R10
    {M1, QN, 1'b1, F_LT},  // R6 NaN on b ignored
    {MZ, P2, 1'b1, F_EQ},  // R6
    {SB, MZ, 1'b0, F_GT},  // R4 subnormal
    {QN, P1, 1'b1, F_UN}   // R6 R5
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic compare(input logic [63:0] a, input logic [63:0] b,
                         input logic zs, input logic xf);
    op_a_i = a; op_b_i = b; zero_sel_i = zs; start_i = 1'b1; xfer_i = xf;
    @(negedge clk);
    start_i = 1'b0; xfer_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1 done", {3'b0, done_o}, 4'b0);
    check("R1 fpsr", fpsr_flags_o, 4'b0);
    check("R1 int", int_flags_o, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      compare(VEC[i][132:69], VEC[i][68:5], VEC[i][4], 1'b0);
      check($sformatf("R2 R3 R4 R5 R6 R10 vec%0d", i), fpsr_flags_o, VEC[i][3:0]);
      check($sformatf("R7 done vec%0d", i), {3'b0, done_o}, 4'b1);
    end

    // R7 no start: done low, flags held
    @(negedge clk);
    check("R7 done low", {3'b0, done_o}, 4'b0);
    check("R7 fpsr hold", fpsr_flags_o, F_UN);
    // R8 compares never touched integer flags
    check("R8 int untouched", int_flags_o, 4'b0);
    xfer_i = 1'b1; @(negedge clk); xfer_i = 1'b0;
    check("R8 xfer copy", int_flags_o, F_UN);
    @(negedge clk);
    check("R8 int hold", int_flags_o, F_UN);

    // R9 coincident transfer copies old flags
    compare(P1, P1, 1'b0, 1'b0);  // fpsr = EQ
    compare(M1, P1, 1'b0, 1'b1);  // new LT, xfer same cycle
    check("R9 old copied", int_flags_o, F_EQ);
    check("R9 fpsr new", fpsr_flags_o, F_LT);
    xfer_i = 1'b1; @(negedge clk); xfer_i = 1'b0;
    check("R9 new copied", int_flags_o, F_LT);

    // R6 op_b varies with zero_sel: result unchanged
    compare(P2, M2, 1'b1, 1'b0);
    check("R6 zero_sel GT", fpsr_flags_o, F_GT);
    compare(P2, PI, 1'b1, 1'b0);
    check("R6 zero_sel GT b=inf", fpsr_flags_o, F_GT);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule